// File: doc/BRIEF.md
# Memory test data generator and checker

This block sits in the data path of a memory exerciser. It supplies the write data for every accepted write beat. It also checks the read data coming back from the memory, one beat at a time. Three data modes are available. The first is a PRBS31 stream that fills the whole bus. The second is one fixed 32-bit word. The third is a pair of 32-bit words that swap on every beat. In the two word modes, the 32-bit value is repeated across the full data bus.

In PRBS mode a second, independent generator produces the sequence expected on the read stream. A test start loads the same seed into both generators, so reads that cover a written area reproduce exactly what was written. Integrity is reported in two ways. A live error flag covers the current measurement interval and is cleared by an interval snapshot. A sticky overall flag latches the first mismatch. Each flag also has a two-bit status, and that status reads as not checked whenever checking does not apply.

Top module: `mtest_pattern_engine`

## Requirements
- R1: After reset, `live_err_o` and `sticky_err_o` are 0. Both PRBS generators hold the all-ones state, and the alternate phase selects word A.
- R2: In PRBS mode (`mode_sel` 0, and 3 also selects PRBS), `wr_data_o` is the next DATA_W bits of the sequence with feedback bit = s[30] xor s[27] (taps for x^31 + x^28 + 1). Each new bit is shifted into s[0], and the first bit produced is placed in bus bit 0. The word advances by DATA_W bits on each `wr_beat_i` and holds in any cycle without a beat.
- R3: A `start_i` pulse loads `seed_i` into both the write and the read generator, where a seed of zero loads all ones instead. It also returns the alternate phase to word A and clears both error flags. Beats presented in the start cycle do not advance any generator.
- R4: In fixed mode (`mode_sel` 1), `wr_data_o` is word A repeated DATA_W/32 times on every beat.
- R5: In alternate mode (`mode_sel` 2), `wr_data_o` is word A repeated across the bus after a start, and switches between A and B after each `wr_beat_i`.
- R6: Word A resets to 0xCAFECAFE and word B to 0xF00DF00D. A `pat_load_i` pulse replaces both with `pat_a_i` and `pat_b_i` from the next cycle on.
- R7: When checking applies, a `rd_beat_i` whose `rd_data_i` differs from the expected read word sets `live_err_o` and `sticky_err_o` in the next cycle. The expected read stream advances by DATA_W bits on each read beat.
- R8: `sticky_err_o` stays 1 until `clr_err_i` or `start_i`. `snap_i` clears `live_err_o`. A mismatch in the same cycle as `snap_i` or `clr_err_i` leaves the flag set.
- R9: In fixed and alternate modes, read data is never compared, so mismatching reads set no flag.
- R10: When `chk_en_i` is 0 or `wr_only_i` is 1, read data is not compared and no flag is set.
- R11: `live_status_o` and `overall_status_o` read 00 (not checked) when checking does not apply (R9, R10). Otherwise they read 01 when the matching flag is clear and 10 when it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Data mode: 0 PRBS, 1 fixed, 2 alternate, 3 PRBS |
| start_i | input | 1 | Test start pulse: seeds the generators, clears the flags |
| seed_i | input | 31 | PRBS seed used on start |
| pat_load_i | input | 1 | Loads both pattern words |
| pat_a_i | input | 32 | New value of word A |
| pat_b_i | input | 32 | New value of word B |
| wr_beat_i | input | 1 | A write beat was accepted |
| wr_data_o | output | DATA_W | Write data for the current beat |
| rd_beat_i | input | 1 | A read beat was accepted |
| rd_data_i | input | DATA_W | Read data of the current beat |
| chk_en_i | input | 1 | Integrity checking enable |
| wr_only_i | input | 1 | Current test is write only |
| snap_i | input | 1 | Interval snapshot: clears the live flag |
| clr_err_i | input | 1 | Clears the sticky flag |
| live_err_o | output | 1 | Error seen in the current interval |
| sticky_err_o | output | 1 | Error seen since the last clear or start |
| live_status_o | output | 2 | Live status: 00 not checked, 01 pass, 10 error |
| overall_status_o | output | 2 | Overall status, same encoding |

## Verification
Write data is checked against a serial bit-level PRBS model under irregular beat gaps. This separates a stream that advances by whole bus words from one that advances per cycle or shifts the wrong way. Reads take a mix of correct words and words with one flipped bit. This separates a true comparison from a stuck flag, and shows whether the read generator stays in step with the beats. The same corrupted reads are repeated in fixed mode, alternate mode, with checking disabled and in write-only tests, where they must leave both flags clear. Directed cases cover the zero seed, the reset pattern words, and snapshot or clear coinciding with a mismatch.

// File: rtl/mtp_pkg.sv
// Shared definitions for the memory test pattern engine.
// Assumes: mode and status encodings are fixed by the block's port contract.
package mtp_pkg;
    typedef enum logic [1:0] {
        MODE_PRBS  = 2'd0,
        MODE_FIXED = 2'd1,
        MODE_ALT   = 2'd2,
        MODE_PRBS2 = 2'd3
    } data_mode_e;

    localparam logic [1:0]  ST_NOTCHK = 2'b00;
    localparam logic [1:0]  ST_PASS   = 2'b01;
    localparam logic [1:0]  ST_ERROR  = 2'b10;

    localparam logic [30:0] PRBS_ONES = {31{1'b1}};
    localparam logic [31:0] PAT_A_RST = 32'hCAFE_CAFE;
    localparam logic [31:0] PAT_B_RST = 32'hF00D_F00D;

    // True when the mode uses the PRBS stream (and so is checkable).
    function automatic logic is_prbs(input logic [1:0] m);
        return (m == MODE_PRBS) || (m == MODE_PRBS2);
    endfunction
endpackage

// File: rtl/mtp_prbs_stream.sv
// PRBS31 word stream: emits DATA_W sequence bits per word, bit 0 first.
// Feedback s[30]^s[27] is shifted into s[0]. Assumes load has priority
// over advance; a zero seed is replaced by all ones to avoid lock-up.
module mtp_prbs_stream #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [30:0]       seed,
    input  logic              adv,
    output logic [DATA_W-1:0] word
);
    import mtp_pkg::*;

    logic [30:0] state_q;
    logic [30:0] state_nx;
    logic [30:0] walk;
    logic        fb;

    // Unroll DATA_W LFSR steps to form the current word and the next state.
    always_comb begin
        walk = state_q;
        fb   = 1'b0;
        word = '0;
        for (int i = 0; i < DATA_W; i++) begin
            fb      = walk[30] ^ walk[27];
            word[i] = fb;
            walk    = {walk[29:0], fb};
        end
        state_nx = walk;
    end

    // State register: reset to all ones, seed on load, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= PRBS_ONES;
        else if (load)   state_q <= (seed == '0) ? PRBS_ONES : seed;
        else if (adv)    state_q <= state_nx;
    end
endmodule

// File: rtl/mtp_word_src.sv
// Write data selector: PRBS word, fixed word A, or A/B alternating per beat.
// Assumes the 32-bit words are replicated DATA_W/32 times across the bus.
module mtp_word_src #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              start,
    input  logic              beat,
    input  logic              pat_load,
    input  logic [31:0]       pat_a_in,
    input  logic [31:0]       pat_b_in,
    input  logic [DATA_W-1:0] prbs_word,
    output logic [DATA_W-1:0] data
);
    import mtp_pkg::*;

    localparam int REPL = DATA_W / 32;

    logic [31:0]       pat_a_q;
    logic [31:0]       pat_b_q;
    logic              phase_q;
    logic [DATA_W-1:0] wide_a;
    logic [DATA_W-1:0] wide_b;

    // Pattern word registers with their fixed reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_a_q <= PAT_A_RST;
            pat_b_q <= PAT_B_RST;
        end else if (pat_load) begin
            pat_a_q <= pat_a_in;
            pat_b_q <= pat_b_in;
        end
    end

    // Alternate phase: back to A on start, toggles on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase_q <= 1'b0;
        else if (start) phase_q <= 1'b0;
        else if (beat)  phase_q <= ~phase_q;
    end

    // Replicate each 32-bit word over the bus lanes.
    for (genvar g = 0; g < REPL; g++) begin : g_lane
        assign wide_a[g*32 +: 32] = pat_a_q;
        assign wide_b[g*32 +: 32] = pat_b_q;
    end

    // Output selection by mode.
    always_comb begin
        unique case (mode_sel)
            MODE_FIXED: data = wide_a;
            MODE_ALT:   data = phase_q ? wide_b : wide_a;
            default:    data = prbs_word;
        endcase
    end
endmodule

// File: rtl/mtp_integrity.sv
// Read integrity tracker: compares read beats with the expected word and
// keeps a live (per interval) and a sticky error flag plus status codes.
// Assumes start has priority; a set in the same cycle wins over a clear.
module mtp_integrity #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              checking,
    input  logic              rd_beat,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    input  logic              snap,
    input  logic              clr_err,
    output logic              live_err,
    output logic              sticky_err,
    output logic [1:0]        live_status,
    output logic [1:0]        overall_status
);
    import mtp_pkg::*;

    logic miss;

    // A compared beat that differs from the expected word.
    assign miss = rd_beat && checking && !start && (rd_data != exp_data);

    // Live flag: cleared by start or snapshot, set by a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)     live_err <= 1'b0;
        else if (start) live_err <= 1'b0;
        else if (snap)  live_err <= miss;
        else if (miss)  live_err <= 1'b1;
    end

    // Sticky flag: cleared only by start or explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       sticky_err <= 1'b0;
        else if (start)   sticky_err <= 1'b0;
        else if (clr_err) sticky_err <= miss;
        else if (miss)    sticky_err <= 1'b1;
    end

    // Status codes reported as not checked when checking does not apply.
    always_comb begin
        live_status    = !checking ? ST_NOTCHK : (live_err   ? ST_ERROR : ST_PASS);
        overall_status = !checking ? ST_NOTCHK : (sticky_err ? ST_ERROR : ST_PASS);
    end
endmodule

// File: rtl/mtest_pattern_engine.sv
// Memory test data generator and checker top level.
// Assumes DATA_W is a multiple of 32 in the range 128..512 and that beat
// strobes mark handshakes already accepted by the AXI side.
module mtest_pattern_engine #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              start_i,
    input  logic [30:0]       seed_i,
    input  logic              pat_load_i,
    input  logic [31:0]       pat_a_i,
    input  logic [31:0]       pat_b_i,
    input  logic              wr_beat_i,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              rd_beat_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              chk_en_i,
    input  logic              wr_only_i,
    input  logic              snap_i,
    input  logic              clr_err_i,
    output logic              live_err_o,
    output logic              sticky_err_o,
    output logic [1:0]        live_status_o,
    output logic [1:0]        overall_status_o
);
    import mtp_pkg::*;

    logic [DATA_W-1:0] wr_prbs;
    logic [DATA_W-1:0] rd_expect;
    logic              wr_adv;
    logic              rd_adv;
    logic              checking;

    // Beats in a start cycle never advance the streams.
    assign wr_adv   = wr_beat_i && !start_i;
    assign rd_adv   = rd_beat_i && !start_i;
    assign checking = chk_en_i && !wr_only_i && is_prbs(mode_sel);

    mtp_prbs_stream #(.DATA_W(DATA_W)) u_wr_stream (
        .clk(clk), .rst_n(rst_n), .load(start_i), .seed(seed_i),
        .adv(wr_adv), .word(wr_prbs)
    );

    mtp_prbs_stream #(.DATA_W(DATA_W)) u_rd_stream (
        .clk(clk), .rst_n(rst_n), .load(start_i), .seed(seed_i),
        .adv(rd_adv), .word(rd_expect)
    );

    mtp_word_src #(.DATA_W(DATA_W)) u_src (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start(start_i),
        .beat(wr_adv), .pat_load(pat_load_i), .pat_a_in(pat_a_i),
        .pat_b_in(pat_b_i), .prbs_word(wr_prbs), .data(wr_data_o)
    );

    mtp_integrity #(.DATA_W(DATA_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .start(start_i), .checking(checking),
        .rd_beat(rd_beat_i), .rd_data(rd_data_i), .exp_data(rd_expect),
        .snap(snap_i), .clr_err(clr_err_i), .live_err(live_err_o),
        .sticky_err(sticky_err_o), .live_status(live_status_o),
        .overall_status(overall_status_o)
    );
endmodule

// File: rtl/mtest_pattern_engine_chk.sv
// Assertion checker for the pattern engine, bound to the top module.
// Assumes only port-level visibility of the design.
module mtest_pattern_engine_chk #(
    parameter int DATA_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              start_i,
    input logic              pat_load_i,
    input logic              wr_beat_i,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              rd_beat_i,
    input logic              chk_en_i,
    input logic              clr_err_i,
    input logic              live_err_o,
    input logic              sticky_err_o,
    input logic [1:0]        overall_status_o
);
    // R2: without a beat, start or load, the PRBS word holds.
    assert_prbs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 && !wr_beat_i && !start_i && !pat_load_i)
        |=> (mode_sel != 2'd0 || $stable(wr_data_o)));

    // R4: fixed mode keeps the same bus word while no new words are loaded.
    assert_fixed_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1 && !pat_load_i)
        |=> (mode_sel != 2'd1 || $stable(wr_data_o)));

    // R7: the live flag can only rise on a read beat.
    assert_live_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_err_o && !rd_beat_i) |=> !live_err_o);

    // R8: the sticky flag holds until clear or start.
    assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_err_o && !clr_err_i && !start_i) |=> sticky_err_o);

    // R9: fixed mode never raises the live flag.
    assert_fixed_no_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_err_o && mode_sel == 2'd1) |=> !live_err_o);

    // R10: with checking disabled the overall status is not checked.
    assert_disabled_notchk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en_i |-> overall_status_o == 2'b00);
endmodule

bind mtest_pattern_engine mtest_pattern_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start_i(start_i),
    .pat_load_i(pat_load_i), .wr_beat_i(wr_beat_i), .wr_data_o(wr_data_o),
    .rd_beat_i(rd_beat_i), .chk_en_i(chk_en_i), .clr_err_i(clr_err_i),
    .live_err_o(live_err_o), .sticky_err_o(sticky_err_o),
    .overall_status_o(overall_status_o)
);

// File: tb/mtest_pattern_engine_bench.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared with a bit-serial model of the requirements.
module mtest_pattern_engine_bench;
    localparam int  DW     = 128;
    localparam time CLK_T  = 10ns;
    localparam int  WD_MAX = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          start_i = 1'b0;
    logic [30:0]   seed_i = '0;
    logic          pat_load_i = 1'b0;
    logic [31:0]   pat_a_i = '0;
    logic [31:0]   pat_b_i = '0;
    logic          wr_beat_i = 1'b0;
    logic [DW-1:0] wr_data_o;
    logic          rd_beat_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          chk_en_i = 1'b1;
    logic          wr_only_i = 1'b0;
    logic          snap_i = 1'b0;
    logic          clr_err_i = 1'b0;
    logic          live_err_o;
    logic          sticky_err_o;
    logic [1:0]    live_status_o;
    logic [1:0]    overall_status_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Model state
    logic [30:0] m_ws, m_rs;
    logic [31:0] m_pa, m_pb;
    logic        m_ph, m_live, m_sticky;

    always #(CLK_T/2) clk = ~clk;

    mtest_pattern_engine #(.DATA_W(DW)) u_mtest_pattern_engine (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start_i(start_i),
        .seed_i(seed_i), .pat_load_i(pat_load_i), .pat_a_i(pat_a_i),
        .pat_b_i(pat_b_i), .wr_beat_i(wr_beat_i), .wr_data_o(wr_data_o),
        .rd_beat_i(rd_beat_i), .rd_data_i(rd_data_i), .chk_en_i(chk_en_i),
        .wr_only_i(wr_only_i), .snap_i(snap_i), .clr_err_i(clr_err_i),
        .live_err_o(live_err_o), .sticky_err_o(sticky_err_o),
        .live_status_o(live_status_o), .overall_status_o(overall_status_o)
    );

    function automatic logic [DW-1:0] prbs_word(input logic [30:0] s);
        logic [30:0] t = s;
        logic [DW-1:0] w = '0;
        for (int i = 0; i < DW; i++) begin
            w[i] = t[30] ^ t[27];
            t = {t[29:0], w[i]};
        end
        return w;
    endfunction

    function automatic logic [30:0] prbs_next(input logic [30:0] s);
        logic [30:0] t = s;
        for (int i = 0; i < DW; i++) t = {t[29:0], t[30] ^ t[27]};
        return t;
    endfunction

    function automatic logic [DW-1:0] rep(input logic [31:0] v);
        return {(DW/32){v}};
    endfunction

    function automatic logic checking_now();
        return chk_en_i && !wr_only_i && (mode_sel == 2'd0 || mode_sel == 2'd3);
    endfunction

    function automatic logic [DW-1:0] exp_wr();
        if (mode_sel == 2'd1) return rep(m_pa);
        if (mode_sel == 2'd2) return m_ph ? rep(m_pb) : rep(m_pa);
        return prbs_word(m_ws);
    endfunction

    function automatic logic [1:0] exp_st(input logic f);
        if (!checking_now()) return 2'b00;
        return f ? 2'b10 : 2'b01;
    endfunction

    task automatic chk_vec(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all();
        string wr_req;
        wr_req = (mode_sel == 2'd1) ? "R4 fixed data" :
                 (mode_sel == 2'd2) ? "R5 alternate data" : "R2 prbs data";
        chk_vec(wr_req, wr_data_o, exp_wr());
        chk_vec("R7 live flag", DW'(live_err_o), DW'(m_live));
        chk_vec("R8 sticky flag", DW'(sticky_err_o), DW'(m_sticky));
        chk_vec("R11 live status", DW'(live_status_o), DW'(exp_st(m_live)));
        chk_vec("R11 overall status", DW'(overall_status_o), DW'(exp_st(m_sticky)));
    endtask

    // One clock: model the edge, wait, compare, then drop the pulses.
    task automatic tick();
        logic mm;
        mm = rd_beat_i && checking_now() && !start_i && (rd_data_i != prbs_word(m_rs));
        @(posedge clk);
        #1;
        if (pat_load_i) begin m_pa = pat_a_i; m_pb = pat_b_i; end
        if (start_i) begin
            m_ws = (seed_i == '0) ? 31'h7FFFFFFF : seed_i;
            m_rs = m_ws; m_ph = 1'b0; m_live = 1'b0; m_sticky = 1'b0;
        end else begin
            if (wr_beat_i) begin m_ws = prbs_next(m_ws); m_ph = ~m_ph; end
            if (rd_beat_i) m_rs = prbs_next(m_rs);
            m_live   = snap_i    ? mm : (m_live | mm);
            m_sticky = clr_err_i ? mm : (m_sticky | mm);
        end
        chk_all();
        start_i = 0; pat_load_i = 0; wr_beat_i = 0; rd_beat_i = 0;
        snap_i = 0; clr_err_i = 0;
    endtask

    task automatic read_beat(input logic corrupt);
        rd_beat_i = 1;
        rd_data_i = prbs_word(m_rs) ^ (corrupt ? (DW'(1) << ($urandom % DW)) : '0);
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_MAX) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_MAX);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ws = 31'h7FFFFFFF; m_rs = 31'h7FFFFFFF;
        m_pa = 32'hCAFECAFE; m_pb = 32'hF00DF00D;
        m_ph = 0; m_live = 0; m_sticky = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1: reset state
        chk_vec("R1 prbs word from all ones", wr_data_o, prbs_word(31'h7FFFFFFF));
        chk_vec("R1 flags clear", DW'({live_err_o, sticky_err_o}), '0);
        // R6: reset pattern words
        mode_sel = 2'd1; #1;
        chk_vec("R6 reset word A", wr_data_o, rep(32'hCAFECAFE));
        mode_sel = 2'd2; #1;
        chk_vec("R6 reset word B phase A", wr_data_o, rep(32'hCAFECAFE));
        wr_beat_i = 1; tick();
        chk_vec("R6 reset word B", wr_data_o, rep(32'hF00DF00D));

        // R3: zero seed loads all ones
        mode_sel = 2'd0; seed_i = '0; start_i = 1; wr_beat_i = 1; tick();
        chk_vec("R3 zero seed", wr_data_o, prbs_word(31'h7FFFFFFF));

        // R2/R3: random seed, irregular write beats
        seed_i = 31'($urandom); start_i = 1; tick();
        chk_vec("R3 seed load", wr_data_o, prbs_word(seed_i));
        for (int i = 0; i < 60; i++) begin wr_beat_i = ($urandom % 3) != 0; tick(); end

        // R7: clean reads pass, one corrupt read flags
        for (int i = 0; i < 20; i++) read_beat(1'b0);
        read_beat(1'b1);
        chk_vec("R7 live after mismatch", DW'(live_err_o), DW'(1));
        // R8: snapshot clears live, sticky remains
        snap_i = 1; tick();
        chk_vec("R8 live after snap", DW'(live_err_o), DW'(0));
        chk_vec("R8 sticky after snap", DW'(sticky_err_o), DW'(1));
        // R8: snapshot with a mismatch leaves live set
        snap_i = 1; read_beat(1'b1);
        chk_vec("R8 snap and mismatch", DW'(live_err_o), DW'(1));
        clr_err_i = 1; tick();
        chk_vec("R8 sticky after clear", DW'(sticky_err_o), DW'(0));

        // R9: fixed and alternate modes ignore bad reads
        pat_a_i = $urandom; pat_b_i = $urandom; pat_load_i = 1; snap_i = 1; tick();
        mode_sel = 2'd1;
        for (int i = 0; i < 5; i++) begin wr_beat_i = 1; read_beat(1'b1); end
        chk_vec("R9 fixed ignores reads", DW'({live_err_o, sticky_err_o}), '0);
        mode_sel = 2'd2; start_i = 1; tick();
        chk_vec("R5 phase A after start", wr_data_o, rep(pat_a_i));
        for (int i = 0; i < 6; i++) begin wr_beat_i = ($urandom % 2) != 0; read_beat(1'b1); end
        chk_vec("R9 alternate ignores reads", DW'({live_err_o, sticky_err_o}), '0);

        // R10: disabled or write-only
        mode_sel = 2'd0; start_i = 1; tick();
        chk_en_i = 0; read_beat(1'b1);
        chk_vec("R10 disabled no flag", DW'({live_err_o, sticky_err_o}), '0);
        chk_en_i = 1; wr_only_i = 1; read_beat(1'b1);
        chk_vec("R10 write only no flag", DW'({live_err_o, sticky_err_o}), '0);
        chk_vec("R11 write only not checked", DW'(overall_status_o), DW'(2'b00));
        wr_only_i = 0;

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            mode_sel   = ($urandom % 4 == 0) ? 2'($urandom) : mode_sel;
            chk_en_i   = ($urandom % 10) != 0;
            wr_only_i  = ($urandom % 12) == 0;
            start_i    = ($urandom % 200) == 0;
            seed_i     = 31'($urandom);
            pat_load_i = ($urandom % 50) == 0;
            pat_a_i    = $urandom; pat_b_i = $urandom;
            wr_beat_i  = ($urandom % 2) != 0;
            snap_i     = ($urandom % 40) == 0;
            clr_err_i  = ($urandom % 60) == 0;
            if ($urandom % 2) read_beat(($urandom % 16) == 0);
            else tick();
        end
        finish_run();
    end
endmodule